// File: doc/BRIEF.md
# Watch-Style Real-Time Clock with Alarm and Stopwatch

The block keeps the time of day from a 32.768 kHz clock. A prescaler turns that clock into a one-second tick. Each tick advances a counter made of seconds, minutes, hours and a 15-bit day number. The same tick drives two other functions: an alarm comparator and a countdown stopwatch. Software sets up everything through a small register bus. It writes the time, the alarm and the stopwatch start value, and reads them back with single-cycle combinational reads.

Six event sources set their own sticky status bits: second, minute rollover, hour rollover, day rollover, alarm match and stopwatch expiry. Software clears a status bit by writing 1 to it. Two separate masks select which pending bits drive the interrupt line and which drive the wake-up request for a sleeping system. Clearing the prescale enable makes the tick fire on every input clock, so long time spans can be tested quickly.

The stopwatch is a two-state machine:
- **SW_IDLE**: the counter holds zero.
- **SW_RUN**: the counter moves down by one on each tick.
- Transitions:
  - *start*, SW_IDLE to SW_RUN: a nonzero value is loaded.
  - *reload*, SW_RUN to SW_RUN: a nonzero value is loaded while running.
  - *abort*, SW_RUN to SW_IDLE: zero is loaded.
  - *expire*, SW_RUN to SW_IDLE: a tick arrives while the count is 1. The count goes to 0 and the expiry event fires.

Top module: `rtc_core`

## Requirements
- R1: With the prescale enable set, the tick fires once every DIV clock cycles. After reset, or after a write to the time register, the seconds field first advances on the DIV-th rising edge.
- R2: With control register (address 6) bit 0 clear, the tick fires on every clock cycle. That bit reads back and resets to 1.
- R3: Seconds and minutes go from 59 to 0 and carry into the next field. Hours go from 23 to 0 and carry into the day. A field written above its last value also goes to 0 on its next increment.
- R4: The 15-bit day counter goes from 32767 to 0 when the hours wrap. That same tick sets the day event.
- R5: The time register (address 0) packs day in bits 31:17, hours in 16:12, minutes in 11:6 and seconds in 5:0. A write loads it directly, and any tick in the cycle of that write is dropped.
- R6: The alarm register (address 1) uses the same packing. Status bit 4 is set by the tick after which the time equals the alarm.
- R7: Writing a nonzero value to the stopwatch register (address 2, low 16 bits) loads it and starts the countdown of one per tick. On reaching 0 the stopwatch sets status bit 5 and holds 0. Writing 0 stops it.
- R8: The status register (address 5) sets its bits from events as follows:
  - bit 0: every second
  - bit 1: minute rollover
  - bit 2: hour rollover
  - bit 3: day rollover
  - bit 4: alarm
  - bit 5: stopwatch expiry

  The bits are sticky. Writing 1 to a bit clears it, but an event in the same cycle keeps it set.
- R9: irq is the OR of the status bits masked by the interrupt enable register (address 3, bits 5:0). wake is the OR of the status bits masked by the wake enable register (address 4, bits 5:0).
- R10: After reset the following hold:
  - the time, alarm, stopwatch, status and both enable registers read 0
  - the control register reads 1
  - unused bits read 0
  - address 7 always reads 0, and writes to it change nothing

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench builds the block with DIV = 4, so a second lasts four cycles. This lets prescaler phase, tick drops on time writes and minute rollovers all occur within a few hundred cycles. Day wrap and out-of-range fields are reached by preloading values near the limits with the prescaler bypassed, so each cycle is one second. A behavioural model runs a random phase of bus writes to all addresses and compares read data, irq and wake every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int SEC_W      = 6;
    localparam int MIN_W      = 6;
    localparam int HOUR_W     = 5;
    localparam int DAY_W      = 15;
    localparam int SEC_LAST   = 59;
    localparam int MIN_LAST   = 59;
    localparam int HOUR_LAST  = 23;

    localparam int NUM_EV     = 6;
    localparam int EV_SEC     = 0;
    localparam int EV_MIN     = 1;
    localparam int EV_HOUR    = 2;
    localparam int EV_DAY     = 3;
    localparam int EV_ALARM   = 4;
    localparam int EV_SWATCH  = 5;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic [SEC_W-1:0]  second;
    } rtc_time_t;

    localparam int TIME_W = $bits(rtc_time_t);

    typedef enum logic [2:0] {
        RA_TIME   = 3'd0,
        RA_ALARM  = 3'd1,
        RA_SWATCH = 3'd2,
        RA_IEN    = 3'd3,
        RA_WEN    = 3'd4,
        RA_STAT   = 3'd5,
        RA_CTRL   = 3'd6,
        RA_NONE   = 3'd7
    } reg_addr_e;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sw_state_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV > 1) begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            logic          at_top;

            assign at_top = (cnt == CW'(DIV - 1));
            assign tick   = (!en || at_top) && !restart;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt <= '0;
                else if (restart || !en || at_top)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                (en && tick) ##1 en |-> !tick); // R1
        end else begin : g_pass
            assign tick = !restart;
        end
    endgenerate
endmodule

// File: rtl/rtc_clock.sv
module rtc_clock
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      ld_time,
    input  logic      ld_alarm,
    input  rtc_time_t wdata,
    output rtc_time_t now,
    output rtc_time_t alarm,
    output logic      ev_sec,
    output logic      ev_min,
    output logic      ev_hour,
    output logic      ev_day,
    output logic      ev_alarm
);
    rtc_time_t nxt;
    logic      c_min, c_hour, c_day;

    always_comb begin
        nxt    = now;
        c_min  = (now.second >= SEC_W'(SEC_LAST));
        c_hour = c_min && (now.minute >= MIN_W'(MIN_LAST));
        c_day  = c_hour && (now.hour >= HOUR_W'(HOUR_LAST));
        nxt.second = c_min ? '0 : now.second + 1'b1;
        if (c_min)
            nxt.minute = (now.minute >= MIN_W'(MIN_LAST)) ? '0 : now.minute + 1'b1;
        if (c_hour)
            nxt.hour = (now.hour >= HOUR_W'(HOUR_LAST)) ? '0 : now.hour + 1'b1;
        if (c_day)
            nxt.day = now.day + 1'b1;
    end

    assign ev_sec   = tick;
    assign ev_min   = tick && c_min;
    assign ev_hour  = tick && c_hour;
    assign ev_day   = tick && c_day;
    assign ev_alarm = tick && (nxt == alarm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            now <= '0;
        else if (ld_time)
            now <= wdata;
        else if (tick)
            now <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            alarm <= '0;
        else if (ld_alarm)
            alarm <= wdata;
    end

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now.second == SEC_W'(SEC_LAST)) |=> (now.second == '0)); // R3
    AST_DAY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now.hour == HOUR_W'(HOUR_LAST) && now.minute == MIN_W'(MIN_LAST)
         && now.second == SEC_W'(SEC_LAST))
        |=> (now.day == $past(now.day) + 1'b1)); // R4
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch
    import rtc_pkg::*;
#(
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    output logic [SW_W-1:0] count,
    output logic            done
);
    sw_state_e state, state_nxt;
    logic      last_one;

    assign last_one = (count == SW_W'(1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            SW_IDLE: if (load && load_val != '0) state_nxt = SW_RUN;
            SW_RUN: begin
                if (load)
                    state_nxt = (load_val != '0) ? SW_RUN : SW_IDLE;
                else if (tick && last_one)
                    state_nxt = SW_IDLE;
            end
            default: state_nxt = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SW_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (state == SW_RUN && tick)
            count <= count - 1'b1;
    end

    always_comb begin
        done = 1'b0;
        unique case (state)
            SW_IDLE: done = 1'b0;
            SW_RUN:  done = tick && !load && last_one;
            default: done = 1'b0;
        endcase
    end

    AST_SW_EXPIRE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == SW_IDLE && count == '0)); // R7
    AST_SW_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_IDLE && !load) |=> $stable(count)); // R7
endmodule

// File: rtl/rtc_events.sv
module rtc_events #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] wen,
    output logic [N-1:0] status,
    output logic         irq,
    output logic         wake
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    status[i] <= 1'b0;
                else if (set[i])
                    status[i] <= 1'b1;
                else if (clr[i])
                    status[i] <= 1'b0;
            end

            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (status[i] && !clr[i]) |=> status[i]); // R8
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> status[i]); // R8
        end
    endgenerate

    assign irq  = |(status & ien);
    assign wake = |(status & wen);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV  = 32768,
    parameter int SW_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        wake
);
    localparam int DATA_W = TIME_W;

    logic              we;
    logic              wr_time, wr_alarm, wr_sw, wr_ien, wr_wen, wr_stat, wr_ctrl;
    logic              tick;
    logic              pre_en;
    logic [NUM_EV-1:0] ien, wen, status, ev_set, ev_clr;
    rtc_time_t         now, alarm;
    logic [SW_W-1:0]   sw_count;
    logic              sw_done;
    logic              e_sec, e_min, e_hour, e_day, e_alarm;
    reg_addr_e         ra;

    assign ra       = reg_addr_e'(bus_addr);
    assign we       = bus_sel && bus_wr;
    assign wr_time  = we && ra == RA_TIME;
    assign wr_alarm = we && ra == RA_ALARM;
    assign wr_sw    = we && ra == RA_SWATCH;
    assign wr_ien   = we && ra == RA_IEN;
    assign wr_wen   = we && ra == RA_WEN;
    assign wr_stat  = we && ra == RA_STAT;
    assign wr_ctrl  = we && ra == RA_CTRL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien    <= '0;
            wen    <= '0;
            pre_en <= 1'b1;
        end else begin
            if (wr_ien)  ien    <= bus_wdata[NUM_EV-1:0];
            if (wr_wen)  wen    <= bus_wdata[NUM_EV-1:0];
            if (wr_ctrl) pre_en <= bus_wdata[0];
        end
    end

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pre_en),
        .restart (wr_time),
        .tick    (tick)
    );

    rtc_clock u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld_time  (wr_time),
        .ld_alarm (wr_alarm),
        .wdata    (rtc_time_t'(bus_wdata)),
        .now      (now),
        .alarm    (alarm),
        .ev_sec   (e_sec),
        .ev_min   (e_min),
        .ev_hour  (e_hour),
        .ev_day   (e_day),
        .ev_alarm (e_alarm)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_sw),
        .load_val (bus_wdata[SW_W-1:0]),
        .count    (sw_count),
        .done     (sw_done)
    );

    always_comb begin
        ev_set             = '0;
        ev_set[EV_SEC]     = e_sec;
        ev_set[EV_MIN]     = e_min;
        ev_set[EV_HOUR]    = e_hour;
        ev_set[EV_DAY]     = e_day;
        ev_set[EV_ALARM]   = e_alarm;
        ev_set[EV_SWATCH]  = sw_done;
    end

    assign ev_clr = wr_stat ? bus_wdata[NUM_EV-1:0] : '0;

    rtc_events #(.N(NUM_EV)) u_ev (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (ev_set),
        .clr    (ev_clr),
        .ien    (ien),
        .wen    (wen),
        .status (status),
        .irq    (irq),
        .wake   (wake)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (ra)
            RA_TIME:   bus_rdata = now;
            RA_ALARM:  bus_rdata = alarm;
            RA_SWATCH: bus_rdata = {{(DATA_W-SW_W){1'b0}}, sw_count};
            RA_IEN:    bus_rdata = {{(DATA_W-NUM_EV){1'b0}}, ien};
            RA_WEN:    bus_rdata = {{(DATA_W-NUM_EV){1'b0}}, wen};
            RA_STAT:   bus_rdata = {{(DATA_W-NUM_EV){1'b0}}, status};
            RA_CTRL:   bus_rdata = {{(DATA_W-1){1'b0}}, pre_en};
            RA_NONE:   bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0 && !(|ev_set)) |=> !irq && !wake); // R9
endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_core #(.DIV(DIV), .SW_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    // behavioural reference model
    int m_pc, m_sec, m_min, m_hr, m_day, m_alarm, m_sw, m_stat, m_ien, m_wen;
    bit m_run, m_pre;
    bit t_we, t_tk, t_twr, t_cm, t_ch, t_cd;
    int t_ev, t_clr, t_s, t_m, t_h, t_d;

    function automatic int pack(int d, int h, int m, int s);
        return ((d & 32'h7FFF) << 17) | ((h & 31) << 12) | ((m & 63) << 6) | (s & 63);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_alarm = 0;
            m_sw = 0; m_run = 0; m_stat = 0; m_ien = 0; m_wen = 0; m_pre = 1;
        end else begin
            t_we  = bus_sel && bus_wr;
            t_twr = t_we && bus_addr == 3'd0;
            t_ev  = 0;
            t_tk  = m_pre ? (m_pc == DIV - 1) : 1'b1;
            if (t_twr) t_tk = 0;
            if (t_twr || !m_pre) m_pc = 0;
            else m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
            if (t_tk) begin
                t_ev = 1;
                t_s = m_sec; t_m = m_min; t_h = m_hr; t_d = m_day;
                t_cm = t_s >= 59; t_s = t_cm ? 0 : t_s + 1;
                t_ch = t_cm && t_m >= 59;
                if (t_cm) t_m = (t_m >= 59) ? 0 : t_m + 1;
                t_cd = t_ch && t_h >= 23;
                if (t_ch) t_h = (t_h >= 23) ? 0 : t_h + 1;
                if (t_cd) t_d = (t_d + 1) & 32'h7FFF;
                if (t_cm) t_ev |= 2;
                if (t_ch) t_ev |= 4;
                if (t_cd) t_ev |= 8;
                if (pack(t_d, t_h, t_m, t_s) == m_alarm) t_ev |= 16;
                m_sec = t_s; m_min = t_m; m_hr = t_h; m_day = t_d;
            end
            if (t_twr) begin
                m_sec = bus_wdata[5:0]; m_min = bus_wdata[11:6];
                m_hr = bus_wdata[16:12]; m_day = bus_wdata[31:17];
            end
            if (t_we && bus_addr == 3'd2) begin
                m_sw = bus_wdata[15:0]; m_run = (m_sw != 0);
            end else if (m_run && t_tk) begin
                if (m_sw == 1) begin m_sw = 0; m_run = 0; t_ev |= 32; end
                else m_sw = m_sw - 1;
            end
            t_clr = (t_we && bus_addr == 3'd5) ? (bus_wdata & 32'h3F) : 0;
            m_stat = ((m_stat & ~t_clr) | t_ev) & 32'h3F;
            if (t_we && bus_addr == 3'd1) m_alarm = bus_wdata;
            if (t_we && bus_addr == 3'd3) m_ien = bus_wdata & 32'h3F;
            if (t_we && bus_addr == 3'd4) m_wen = bus_wdata & 32'h3F;
            if (t_we && bus_addr == 3'd6) m_pre = bus_wdata[0];
        end
    end

    function automatic int mread(logic [2:0] a);
        case (a)
            3'd0: return pack(m_day, m_hr, m_min, m_sec);
            3'd1: return m_alarm;
            3'd2: return m_sw;
            3'd3: return m_ien;
            3'd4: return m_wen;
            3'd5: return m_stat;
            3'd6: return int'(m_pre);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R3";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3, 3'd4: return "R9";
            3'd5: return "R8";
            3'd6: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag_of(bus_addr), "model read", bus_rdata, mread(bus_addr));
            chk("R9", "irq", {31'd0, irq}, ((m_stat & m_ien) != 0) ? 1 : 0);
            chk("R9", "wake", {31'd0, wake}, ((m_stat & m_wen) != 0) ? 1 : 0);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10 reset state
        peek(3'd0, v); chk("R10", "time after reset", v, 0);
        peek(3'd6, v); chk("R10", "ctrl after reset", v, 1);
        peek(3'd5, v); chk("R10", "status after reset", v, 0);
        peek(3'd7, v); chk("R10", "addr7 after reset", v, 0);
        peek(3'd2, v); chk("R10", "stopwatch after reset", v, 0);

        // R5 load and R1 prescale phase
        wr(3'd0, pack(5, 10, 20, 30));
        peek(3'd0, v); chk("R5", "time load", v, pack(5, 10, 20, 30));
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R1", "before second", bus_rdata, pack(5, 10, 20, 30));
        @(negedge clk); chk("R1", "second advance", bus_rdata, pack(5, 10, 20, 31));

        // R2 bypass, R5 tick drop
        wr(3'd6, 0);
        wr(3'd0, pack(0, 0, 0, 0));
        peek(3'd0, v); chk("R5", "tick dropped on write", v, 0);
        @(negedge clk); chk("R2", "tick each cycle 1", bus_rdata, 1);
        @(negedge clk); chk("R2", "tick each cycle 2", bus_rdata, 2);

        // R4 day wrap, R8 events
        wr(3'd0, pack(32'h7FFF, 23, 59, 50));
        wr(3'd5, 32'h3F);
        bus_addr = 3'd5;
        repeat (7) @(posedge clk);
        @(negedge clk); chk("R8", "status before wrap", bus_rdata, 32'h01);
        @(negedge clk); chk("R8", "status at day wrap", bus_rdata, 32'h1F);
        bus_addr = 3'd0; #1;
        chk("R4", "day wrap to zero", bus_rdata, 0);

        wr(3'd5, 32'h01);
        peek(3'd5, v); chk("R8", "set wins over clear", v[0], 1);
        wr(3'd5, 32'h1E);
        peek(3'd5, v); chk("R8", "write one clears", v, 32'h01);

        // R3 out of range fields
        wr(3'd0, pack(0, 3, 5, 62));
        bus_addr = 3'd0; @(posedge clk);
        @(negedge clk); chk("R3", "seconds out of range", bus_rdata, pack(0, 3, 6, 0));
        wr(3'd0, pack(0, 3, 61, 59));
        bus_addr = 3'd0; @(posedge clk);
        @(negedge clk); chk("R3", "minutes out of range", bus_rdata, pack(0, 4, 0, 0));

        // R6 alarm
        wr(3'd1, pack(0, 1, 0, 5));
        wr(3'd0, pack(0, 1, 0, 0));
        wr(3'd5, 32'h10);
        bus_addr = 3'd5;
        repeat (2) @(posedge clk);
        @(negedge clk); chk("R6", "alarm not yet", bus_rdata[4], 0);
        @(negedge clk); chk("R6", "alarm match", bus_rdata[4], 1);

        // R9 masks
        wr(3'd3, 32'h10);
        @(negedge clk); chk("R9", "irq enabled", irq, 1);
        chk("R9", "wake masked", wake, 0);
        wr(3'd4, 32'h10);
        @(negedge clk); chk("R9", "wake enabled", wake, 1);
        wr(3'd5, 32'h10);
        @(negedge clk); chk("R9", "irq after clear", irq, 0);
        chk("R9", "wake after clear", wake, 0);

        // R7 stopwatch
        wr(3'd5, 32'h20);
        wr(3'd2, 3);
        peek(3'd2, v); chk("R7", "load", v, 3);
        @(negedge clk); chk("R7", "count 2", bus_rdata, 2);
        @(negedge clk); chk("R7", "count 1", bus_rdata, 1);
        @(negedge clk); chk("R7", "expired", bus_rdata, 0);
        bus_addr = 3'd5; #1; chk("R7", "expiry status", bus_rdata[5], 1);
        bus_addr = 3'd2;
        @(negedge clk); chk("R7", "holds zero", bus_rdata, 0);
        wr(3'd5, 32'h20);
        wr(3'd2, 10);
        wr(3'd2, 0);
        bus_addr = 3'd2;
        repeat (3) @(negedge clk);
        chk("R7", "stopped by zero write", bus_rdata, 0);
        bus_addr = 3'd5; #1; chk("R7", "no expiry after stop", bus_rdata[5], 0);

        // R10 unused address
        wr(3'd7, 32'hFFFF_FFFF);
        peek(3'd7, v); chk("R10", "addr7 reads zero", v, 0);
        peek(3'd3, v); chk("R10", "ien untouched", v, 32'h10);
        peek(3'd6, v); chk("R10", "ctrl untouched", v, 0);

        // random phase, model compared each cycle
        wr(3'd6, 1);
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            bus_addr = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) begin
                bus_sel = 1; bus_wr = 1;
                case (bus_addr)
                    3'd2: bus_wdata = $urandom_range(0, 20);
                    3'd6: bus_wdata = ($urandom_range(0, 3) == 0) ? 0 : 1;
                    3'd1: bus_wdata = pack(m_day, m_hr, m_min, m_sec + 3);
                    default: bus_wdata = $urandom;
                endcase
            end else begin
                bus_sel = $urandom_range(0, 1); bus_wr = 0;
            end
        end
        @(posedge clk); #1; bus_sel = 0; bus_wr = 0;
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule